// File: doc/BRIEF.md
# Blank Check Status Generator

This block runs a blank check on one flash block and builds the status word a host sees on each status read. A start request carries a block address. The request is checked against two side conditions: a program or erase is suspended, or the block sits in the one-time-programmable region. If either holds, the request is refused with a one-cycle pulse and the bank stays in read mode. Otherwise the bank enters status mode. A scan request with the block address goes to an array-scan model for a fixed number of cycles, and in the last of those cycles the model's all-ones answer is sampled.

While the scan runs, two toggle bits flip on every status read and the done bit reads 0. Once the scan ends, the done bit reads 1 and a result bit tells pass from fail. Only one of the toggle bits keeps flipping. The bank stays in status mode until a reset command arrives after completion. During the scan every command except a status read is ignored, so the scan cannot be suspended. The scan length is a parameter.

Top module: `bc_blank_check`

## Requirements
- R1: A start strobe received in read mode, with susp_i low and otp_i low, raises locked_o and scan_req_o from the next cycle, and scan_blk_o then holds the start address.
- R2: scan_req_o stays high for exactly SCAN_CYCLES cycles. blank_i is sampled in the last of them: 1 means pass and 0 means fail.
- R3: A status read while scanning returns bit 5 = 0, bit 1 = 0, bits 6 and 2 equal, and all other bits 0. Bits 6 and 2 read 0 on the first read after a start and invert on each later read.
- R4: A status read after a pass returns bit 5 = 1 and bit 1 = 1, with bit 2 = 0. Bit 6 continues its per-read inversion from where the scanning reads left it.
- R5: A status read after a fail returns bit 5 = 1, bit 1 = 0 and bit 2 = 0, with bit 6 inverting on each read.
- R6: After completion locked_o stays high until rst_cmd_i is strobed. locked_o is low from the following cycle.
- R7: While scanning, rst_cmd_i and start_i are ignored: the scan runs to its end and scan_blk_o does not change.
- R8: A start strobe in read mode with susp_i or otp_i high gives reject_o high for exactly the next cycle and leaves locked_o low.
- R9: status_o is registered. It changes only in the cycle after a read strobe and holds between reads. It is 0 after reset.
- R10: A status read in read mode returns 8'h00 and does not advance the toggle bits.
- R11: A start strobe after completion, before the reset command, is ignored: there is no new scan and no reject pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Blank-check start strobe |
| blk_addr_i | input | ADDR_W | Block address for the start |
| susp_i | input | 1 | A program or erase is suspended |
| otp_i | input | 1 | Addressed block lies in the OTP region |
| blank_i | input | 1 | Array-scan answer: block is all ones |
| rd_i | input | 1 | Status read strobe |
| rst_cmd_i | input | 1 | Reset command strobe |
| status_o | output | 8 | Status word of the latest read |
| locked_o | output | 1 | Bank is in status mode |
| reject_o | output | 1 | One-cycle refusal pulse |
| scan_req_o | output | 1 | Scan in progress, request to the array model |
| scan_blk_o | output | ADDR_W | Block address under scan |

## Verification
Every result is due one clock after the edge that samples its cause. status_o follows a read by one cycle. locked_o and scan_req_o follow an accepted start by one cycle. reject_o follows a refused start by one cycle and lasts one cycle. The pass or fail state is visible in the cycle after the last scan cycle. The bench keeps a behavioural model that is advanced at each rising edge with the same input values, and compares all outputs 2 ns after that edge. Inputs change only on falling edges, so each comparison lands after the registers have updated and before the next stimulus. Separate checks count the scan cycles and record toggle values across successive reads.

// File: rtl/bc_pkg.sv
package bc_pkg;
  typedef enum logic [1:0] {
    BC_READ = 2'd0,
    BC_SCAN = 2'd1,
    BC_PASS = 2'd2,
    BC_FAIL = 2'd3
  } bc_state_e;

  localparam int STAT_W   = 8;
  localparam int TGL_HI   = 6;
  localparam int DONE_BIT = 5;
  localparam int TGL_LO   = 2;
  localparam int RES_BIT  = 1;

  function automatic logic [STAT_W-1:0] bc_word(bc_state_e s, logic tgl);
    logic [STAT_W-1:0] w;
    w = '0;
    if (s != BC_READ) begin
      w[TGL_HI] = tgl;
      if (s == BC_SCAN) begin
        w[TGL_LO] = tgl;
      end else begin
        w[DONE_BIT] = 1'b1;
        w[RES_BIT]  = (s == BC_PASS);
      end
    end
    return w;
  endfunction
endpackage

// File: rtl/bc_admit.sv
module bc_admit (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic susp_i,
  input  logic otp_i,
  input  logic idle_i,
  output logic accept_o,
  output logic reject_o
);
  logic refuse;

  always_comb begin
    refuse   = start_i && idle_i && (susp_i || otp_i);
    accept_o = start_i && idle_i && !susp_i && !otp_i;
  end

  always_ff @(posedge clk) begin
    if (rst) reject_o <= 1'b0;
    else     reject_o <= refuse;
  end
endmodule

// File: rtl/bc_ctrl.sv
module bc_ctrl #(
  parameter int SCAN_CYCLES = 64,
  parameter int ADDR_W      = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               rst_cmd_i,
  input  logic               blank_i,
  output bc_pkg::bc_state_e  state_o,
  output logic [ADDR_W-1:0]  blk_o
);
  import bc_pkg::*;
  localparam int CNT_W = $clog2(SCAN_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SCAN_CYCLES - 1);

  bc_state_e        st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= BC_READ;
      cnt   <= '0;
      blk_o <= '0;
    end else begin
      case (st)
        BC_READ: begin
          if (accept_i) begin
            st    <= BC_SCAN;
            cnt   <= '0;
            blk_o <= addr_i;
          end
        end
        BC_SCAN: begin
          if (cnt == LAST) st <= blank_i ? BC_PASS : BC_FAIL;
          else             cnt <= cnt + 1'b1;
        end
        default: begin
          if (rst_cmd_i) st <= BC_READ;
        end
      endcase
    end
  end

  assign state_o = st;
endmodule

// File: rtl/bc_status.sv
module bc_status (
  input  logic              clk,
  input  logic              rst,
  input  bc_pkg::bc_state_e state_i,
  input  logic              accept_i,
  input  logic              rd_i,
  output logic [7:0]        status_o
);
  import bc_pkg::*;
  logic tgl;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgl      <= 1'b0;
      status_o <= '0;
    end else begin
      if (rd_i) status_o <= bc_word(state_i, tgl);
      if (accept_i)                           tgl <= 1'b0;
      else if (rd_i && state_i != BC_READ)    tgl <= ~tgl;
    end
  end
endmodule

// File: rtl/bc_blank_check.sv
module bc_blank_check #(
  parameter int SCAN_CYCLES = 64,
  parameter int ADDR_W      = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] blk_addr_i,
  input  logic              susp_i,
  input  logic              otp_i,
  input  logic              blank_i,
  input  logic              rd_i,
  input  logic              rst_cmd_i,
  output logic [7:0]        status_o,
  output logic              locked_o,
  output logic              reject_o,
  output logic              scan_req_o,
  output logic [ADDR_W-1:0] scan_blk_o
);
  import bc_pkg::*;
  bc_state_e st;
  logic      accept;

  bc_admit u_admit (
    .clk(clk), .rst(rst), .start_i(start_i), .susp_i(susp_i), .otp_i(otp_i),
    .idle_i(st == BC_READ), .accept_o(accept), .reject_o(reject_o)
  );

  bc_ctrl #(.SCAN_CYCLES(SCAN_CYCLES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .accept_i(accept), .addr_i(blk_addr_i),
    .rst_cmd_i(rst_cmd_i), .blank_i(blank_i), .state_o(st), .blk_o(scan_blk_o)
  );

  bc_status u_stat (
    .clk(clk), .rst(rst), .state_i(st), .accept_i(accept), .rd_i(rd_i),
    .status_o(status_o)
  );

  assign locked_o   = (st != BC_READ);
  assign scan_req_o = (st == BC_SCAN);
endmodule

// File: rtl/bc_blank_check_chk.sv
module bc_blank_check_chk #(
  parameter int SCAN_CYCLES = 64,
  parameter int ADDR_W      = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              susp_i,
  input logic              otp_i,
  input logic              rd_i,
  input logic              rst_cmd_i,
  input logic [7:0]        status_o,
  input logic              locked_o,
  input logic              reject_o,
  input logic              scan_req_o,
  input logic [ADDR_W-1:0] scan_blk_o
);
  localparam int CW = $clog2(SCAN_CYCLES + 2);
  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst)             run <= '0;
    else if (scan_req_o) run <= run + 1'b1;
    else                 run <= '0;
  end

  // R8
  reject_src_chk: assert property (@(posedge clk) disable iff (rst)
    reject_o |-> $past(start_i && (susp_i || otp_i) && !locked_o));
  // R8
  reject_stays_read_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && (susp_i || otp_i) && !locked_o) |=> !locked_o);
  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (locked_o && !rst_cmd_i) |=> locked_o);
  // R7
  scan_ignores_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (scan_req_o && rst_cmd_i) |=> locked_o);
  // R7
  scan_blk_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (scan_req_o && $past(scan_req_o)) |-> $stable(scan_blk_o));
  // R3
  busy_done_low_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && scan_req_o) |=> (!status_o[5] && !status_o[1] && status_o[6] == status_o[2]));
  // R10
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !locked_o) |=> (status_o == 8'h00));
  // R9
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(status_o));
  // R2
  scan_len_chk: assert property (@(posedge clk) disable iff (rst)
    run <= CW'(SCAN_CYCLES));
  // R2
  scan_end_chk: assert property (@(posedge clk) disable iff (rst)
    (scan_req_o && run == CW'(SCAN_CYCLES - 1)) |=> !scan_req_o);
endmodule

bind bc_blank_check bc_blank_check_chk #(.SCAN_CYCLES(SCAN_CYCLES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .susp_i(susp_i), .otp_i(otp_i),
  .rd_i(rd_i), .rst_cmd_i(rst_cmd_i), .status_o(status_o), .locked_o(locked_o),
  .reject_o(reject_o), .scan_req_o(scan_req_o), .scan_blk_o(scan_blk_o)
);

// File: tb/test_bc_blank_check.sv
`timescale 1ns/1ps
module test_bc_blank_check;
  localparam int N  = 6;
  localparam int AW = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 0, susp_i = 0, otp_i = 0, blank_i = 0, rd_i = 0, rst_cmd_i = 0;
  logic [AW-1:0] blk_addr_i = '0;
  logic [7:0] status_o;
  logic locked_o, reject_o, scan_req_o;
  logic [AW-1:0] scan_blk_o;

  int checks = 0, errors = 0;
  string phase = "R9";
  bit finished = 0;

  always #10 clk = ~clk;

  bc_blank_check #(.SCAN_CYCLES(N), .ADDR_W(AW)) i_bc_blank_check (
    .clk(clk), .rst(rst), .start_i(start_i), .blk_addr_i(blk_addr_i),
    .susp_i(susp_i), .otp_i(otp_i), .blank_i(blank_i), .rd_i(rd_i),
    .rst_cmd_i(rst_cmd_i), .status_o(status_o), .locked_o(locked_o),
    .reject_o(reject_o), .scan_req_o(scan_req_o), .scan_blk_o(scan_blk_o)
  );

  task automatic check(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // behavioural reference: 0 read, 1 scanning, 2 pass, 3 fail
  int m_st = 0, m_cnt = 0, m_blk = 0;
  bit m_t = 0, m_rej = 0;
  logic [7:0] m_stat = 0;
  int scan_len = 0;
  logic [7:0] rd_log[$];

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_blk = 0; m_t = 0; m_rej = 0; m_stat = 0;
    end else begin
      m_rej = 0;
      if (rd_i) begin
        if (m_st == 0) m_stat = 8'h00;
        else begin
          m_stat = 8'h00;
          m_stat[6] = m_t;
          if (m_st == 1) m_stat[2] = m_t;
          else begin
            m_stat[5] = 1'b1;
            m_stat[1] = (m_st == 2);
          end
          m_t = !m_t;
        end
      end
      case (m_st)
        0: if (start_i) begin
             if (susp_i || otp_i) m_rej = 1;
             else begin m_st = 1; m_cnt = 0; m_blk = int'(blk_addr_i); m_t = 0; end
           end
        1: if (m_cnt == N - 1) m_st = blank_i ? 2 : 3; else m_cnt++;
        default: if (rst_cmd_i) m_st = 0;
      endcase
    end
    #2;
    if (!rst) begin
      if (scan_req_o) scan_len++;
      check(phase, "status_o", int'(status_o), int'(m_stat));
      check(phase, "locked_o", int'(locked_o), int'(m_st != 0));
      check(phase, "scan_req_o", int'(scan_req_o), int'(m_st == 1));
      check(phase, "reject_o", int'(reject_o), int'(m_rej));
      check(phase, "scan_blk_o", int'(scan_blk_o), m_blk);
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask
  task automatic clear_in();
    start_i = 0; rd_i = 0; rst_cmd_i = 0;
  endtask
  task automatic do_start(int a, bit s, bit o);
    @(negedge clk); blk_addr_i = AW'(a); susp_i = s; otp_i = o; start_i = 1;
    @(negedge clk); clear_in(); susp_i = 0; otp_i = 0;
  endtask
  task automatic do_read();
    @(negedge clk); rd_i = 1;
    @(negedge clk); clear_in();
    #3 rd_log.push_back(status_o);
  endtask
  task automatic do_rcmd();
    @(negedge clk); rst_cmd_i = 1;
    @(negedge clk); clear_in();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    step(1);
    phase = "R9";
    check("R9", "reset status_o", int'(status_o), 0);
    check("R9", "reset locked_o", int'(locked_o), 0);

    phase = "R10";
    do_read();
    check("R10", "idle read", int'(rd_log[$]), 0);
    rd_log.delete();

    phase = "R1";
    blank_i = 1; scan_len = 0;
    do_start(37, 0, 0);
    check("R1", "scan_blk_o", int'(scan_blk_o), 37);
    phase = "R3";
    do_read(); do_read();
    check("R3", "first read bit6", int'(rd_log[0][6]), 0);
    check("R3", "second read bit6", int'(rd_log[1][6]), 1);
    check("R3", "second read bit2", int'(rd_log[1][2]), 1);
    phase = "R7";
    @(negedge clk); rst_cmd_i = 1; start_i = 1; blk_addr_i = 10'd99;
    @(negedge clk); clear_in();
    check("R7", "locked after ignored cmds", int'(locked_o), 1);
    step(N);
    phase = "R2";
    check("R2", "scan length", scan_len, N);
    phase = "R4";
    rd_log.delete();
    do_read(); do_read(); do_read();
    check("R4", "pass word 1", int'(rd_log[0]), 8'h22);
    check("R4", "pass word 2", int'(rd_log[1]), 8'h62);
    check("R4", "pass word 3", int'(rd_log[2]), 8'h22);
    phase = "R11";
    do_start(5, 0, 0);
    check("R11", "no new scan", int'(scan_req_o), 0);
    check("R11", "no reject", int'(reject_o), 0);
    phase = "R9";
    step(3);
    check("R9", "status held", int'(status_o), 8'h22);
    phase = "R6";
    step(2);
    check("R6", "still locked", int'(locked_o), 1);
    do_rcmd();
    check("R6", "unlocked", int'(locked_o), 0);

    phase = "R5";
    blank_i = 0; scan_len = 0;
    do_start(200, 0, 0);
    step(N + 1);
    check("R2", "scan length fail run", scan_len, N);
    rd_log.delete();
    do_read(); do_read();
    check("R5", "fail word 1", int'(rd_log[0]), 8'h20);
    check("R5", "fail word 2", int'(rd_log[1]), 8'h60);
    do_rcmd();

    phase = "R8";
    @(negedge clk); blk_addr_i = 10'd3; susp_i = 1; start_i = 1;
    @(negedge clk); clear_in(); susp_i = 0;
    check("R8", "reject on suspend", int'(reject_o), 1);
    check("R8", "not locked", int'(locked_o), 0);
    step(1);
    check("R8", "reject one cycle", int'(reject_o), 0);
    do_start(4, 0, 1);
    step(2);
    check("R8", "otp stays read", int'(locked_o), 0);
    step(2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule